// File: doc/BRIEF.md
# Burst Address Sequencer

This block keeps the address of the access in progress and produces the address that goes to a memory array during a four-beat burst. When an access starts, a load request captures the full external address. The two lowest address bits become the starting offset inside an aligned block of four words. Each later advance request moves the offset to the next beat. The upper address bits stay fixed for the whole burst. Reads and writes use the sequencer in the same way, so the block has no notion of direction.

The burst order is chosen when the access is loaded, from a one-bit order select. In linear order the offset counts up from the start and wraps modulo four. In interleaved order the offset is the start XORed with the number of beats taken. In the load cycle itself the new address passes straight through to the array, so the first beat costs no extra cycle. Chip-enable and write-control decoding belong to the surrounding logic and are not part of this block.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset, with load_i low and adv_n_i high, array_addr_o is all zeros.
- R2: While load_i is high, array_addr_o equals load_addr_i in that same cycle. At the clock edge the address and mode_i are captured, and the beat count returns to zero.
- R3: With load_i low, adv_n_i low at a rising edge steps the beat count by one. With adv_n_i high the beat count holds, so array_addr_o does not change.
- R4: With mode_i = 0 captured at load (linear order), array_addr_o[1:0] equals (start + beats) mod 4, where start is load_addr_i[1:0] from the load.
- R5: With mode_i = 1 captured at load (interleaved order), array_addr_o[1:0] equals start XOR beats (mod 4). For example, start 1 gives 1,0,3,2.
- R6: After four advances the offset is back at the start value, and further advances repeat the sequence instead of stopping.
- R7: array_addr_o[ADDR_W-1:2] equals load_addr_i[ADDR_W-1:2] from the most recent load and does not change between loads.
- R8: A load takes priority over an advance in the same cycle. The cycle after such a load shows the start offset, not the start offset plus one beat.
- R9: mode_i is sampled only on a load. Changing it during a burst does not alter the order of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start a new access: capture the address and order |
| load_addr_i | input | ADDR_W | External start address |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | Order select: 0 linear, 1 interleaved |
| array_addr_o | output | ADDR_W | Address presented to the array |

## Verification
The bench aims at start offsets 1 and 3. At those offsets the two orders differ, so a design that swapped them, or that used add where it should XOR, would show the wrong second beat. It drives more than four advances in a row, which catches a counter that saturates at the last beat instead of wrapping. It asserts advance together with load, which exposes a design that lets the advance through and skips the first beat. It also flips the order select in the middle of a burst, which catches a design that reads the select live rather than latching it at load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 2;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        order_e ord;
        ofs_t   start;
    } seed_t;

    function automatic ofs_t lin_offset(input ofs_t start, input ofs_t beat);
        return start + beat;
    endfunction

    function automatic ofs_t xor_offset(input ofs_t start, input ofs_t beat);
        return start ^ beat;
    endfunction

endpackage

// File: rtl/bsq_seed_reg.sv
module bsq_seed_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - OFS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic            mode_i,
    output logic [UP_W-1:0] upper_o,
    output seed_t           seed_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            upper_o      <= '0;
            seed_o.ord   <= ORD_LINEAR;
            seed_o.start <= '0;
        end else if (load_i) begin
            upper_o      <= load_addr_i[ADDR_W-1:OFS_W];
            seed_o.ord   <= order_e'(mode_i);
            seed_o.start <= load_addr_i[OFS_W-1:0];
        end
    end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic adv_n_i,
    output ofs_t beat_o
);
    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            beat_o <= '0;
        end else if (!adv_n_i) begin
            beat_o <= beat_o + ofs_t'(1);
        end
    end
endmodule

// File: rtl/bsq_offset_gen.sv
module bsq_offset_gen
    import burst_seq_pkg::*;
(
    input  seed_t seed_i,
    input  ofs_t  beat_i,
    output ofs_t  ofs_o
);
    localparam int N_ORD = 2;
    ofs_t cand [N_ORD];

    for (genvar g = 0; g < N_ORD; g++) begin : g_order
        if (g == int'(ORD_INTERLEAVE)) begin : g_xor
            assign cand[g] = xor_offset(seed_i.start, beat_i);
        end else begin : g_lin
            assign cand[g] = lin_offset(seed_i.start, beat_i);
        end
    end

    assign ofs_o = cand[seed_i.ord];
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] array_addr_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    logic [UP_W-1:0] upper;
    seed_t           seed;
    ofs_t            beat;
    ofs_t            ofs;

    bsq_seed_reg #(.ADDR_W(ADDR_W)) u_seed (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .mode_i      (mode_i),
        .upper_o     (upper),
        .seed_o      (seed)
    );

    bsq_beat_ctr u_beat (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat)
    );

    bsq_offset_gen u_ofs (
        .seed_i (seed),
        .beat_i (beat),
        .ofs_o  (ofs)
    );

    always_comb begin
        if (load_i) begin
            array_addr_o = load_addr_i;
        end else begin
            array_addr_o = {upper, ofs};
        end
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              adv_n_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] array_addr_o
);
    logic lin_q;
    always_ff @(posedge clk) begin
        if (rst) lin_q <= 1'b1;
        else if (load_i) lin_q <= !mode_i;
    end

    AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
        load_i |-> array_addr_o == load_addr_i); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> (load_i || $stable(array_addr_o))); // R3

    AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i && lin_q) |=>
        (load_i || array_addr_o[OFS_W-1:0] == $past(array_addr_o[OFS_W-1:0]) + ofs_t'(1))); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (load_i || $stable(array_addr_o[ADDR_W-1:OFS_W]))); // R7

    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (load_i || array_addr_o == $past(load_addr_i))); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .load_addr_i  (load_addr_i),
    .adv_n_i      (adv_n_i),
    .mode_i       (mode_i),
    .array_addr_o (array_addr_o)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW-1:0] array_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_upper = 0, m_start = 0, m_beat = 0;
    bit m_il = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
        .adv_n_i(adv_n_i), .mode_i(mode_i), .array_addr_o(array_addr_o)
    );

    function automatic int model_out(bit ld, int a);
        int o;
        if (ld) return a;
        o = m_il ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
        return m_upper * 4 + o;
    endfunction

    task automatic cyc(input bit ld, input int a, input bit advn, input bit md, input string tag);
        int exp_v;
        @(negedge clk);
        load_i = ld; load_addr_i = AW'(a); adv_n_i = advn; mode_i = md;
        #1;
        exp_v = model_out(ld, a);
        checks++;
        if (int'(array_addr_o) != exp_v) begin
            errors++;
            $display("FAIL %s: array_addr_o=%h expected %h", tag, array_addr_o, exp_v);
        end
        @(posedge clk);
        if (ld) begin
            m_upper = a / 4; m_start = a % 4; m_beat = 0; m_il = md;
        end else if (!advn) begin
            m_beat = (m_beat + 1) % 4;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cyc(0, 0, 1, 0, "R1");
        // linear from start 1, six advances to cross the wrap
        cyc(1, 'h12345, 1, 0, "R2");
        for (int i = 0; i < 6; i++) cyc(0, 'h3ffff, 0, 1, (i >= 3) ? "R6" : "R4");
        cyc(0, 0, 1, 0, "R3");
        cyc(0, 0, 1, 0, "R7");
        // interleaved from start 1: 1,0,3,2
        cyc(1, 'h2aa81, 1, 1, "R2");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, (i >= 3) ? "R6" : "R5");
        // interleaved from start 3 with idle gaps
        cyc(1, 'h00013, 1, 1, "R2");
        for (int i = 0; i < 8; i++) cyc(0, 'h1, i[0], 0, "R5");
        // load with simultaneous advance
        cyc(1, 'h0f00e, 0, 0, "R8");
        cyc(0, 0, 1, 1, "R8");
        // mode change mid burst
        cyc(1, 'h05551, 1, 0, "R2");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, ~i[0], "R9");
        cyc(1, 'h05551, 1, 1, "R2");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, i[0], "R9");
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            bit ld = ($urandom % 6) == 0;
            cyc(ld, int'($urandom % (1 << AW)), bit'($urandom % 3 == 0), bit'($urandom), "R3");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule